// File: doc/BRIEF.md
# Self-Test Control and Status Unit

This block runs the built-in self-test of a four-channel converter card. Software drives it over a small register bus. One bit of a test-enable word starts a background test. While that test runs, a heartbeat writes a fixed marker into a verify register once per second. Software can clear the verify register at any time and read it again later to confirm that the background test is still alive.

A second bit of the test-enable word starts an offline test. A sequencer walks the channels in order and gives each channel an equal slice of a time budget that never exceeds ten seconds. For each channel it records the pass/fail verdict of an external accuracy checker. These offline verdicts stay hidden until software clears the offline bit. At that point they are merged into the per-channel status register.

Background failures go straight into the same status register. Every status bit latches and is cleared when software reads it. An interrupt request follows the status register whenever interrupts are enabled. A test-active output is high while the offline bit is set, so that neighbouring logic can suspend its overcurrent monitoring. The one-second time base is a parameter counted in system clocks.

Top module: `selftest_ctrl`

## Requirements
- R1: Writing address 0 stores only bit 2 (background enable) and bit 3 (offline enable); all other written bits are ignored. Reading address 0 returns those two bits in place with every other bit 0. After reset all registers and outputs are 0.
- R2: While the background bit is set, the verify register (address 1, bits 7:0) becomes 0x55 exactly TICKS_PER_SEC cycles after the bit is set, and again every TICKS_PER_SEC cycles after that.
- R3: A software write to address 1 loads bits 7:0 into the verify register. If a heartbeat falls in the same cycle, the heartbeat wins. A cleared register reads 0x55 again within TICKS_PER_SEC cycles while background testing runs.
- R4: After the offline bit is set, the sequencer spends one idle cycle. It then selects channel 1 through channel 4 in turn, each for STEP cycles, where STEP = TICKS_PER_SEC*min(OFFLINE_SECS,10)/4. `chan_sel` bit i is high one-hot for channel i+1. After the last channel, `seq_done` is raised.
- R5: Clearing the offline bit returns the sequencer to idle one cycle later, which makes `chan_sel` zero and `seq_done` low.
- R6: Each channel's offline verdict is `chk_fail[i]` sampled on the last cycle of its step. Verdicts are merged into the status register only when a write clears the offline bit while it is set.
- R7: Status (address 2) bit i reports channel i+1, where 1 means non-compliant. While the background bit is set, a high `chk_fail[i]` sets bit i. Set bits hold until read. While the background bit is clear, `chk_fail` does not affect status.
- R8: A read of address 2 returns the status value and clears the bits it returned. A bit being set in the same cycle as the read stays set.
- R9: `irq` is high exactly when `irq_en` is high and at least one status bit is set.
- R10: `test_active` equals the stored offline bit.
- R11: `bus_rdata` is loaded on the clock edge that samples `bus_rd` and holds its value when no read is made. Unmapped address 3 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 2 | Register address (0 enable, 1 verify, 2 status) |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Registered read data |
| irq_en | input | 1 | Interrupt enable |
| chk_fail | input | 4 | Per-channel non-compliance verdict from the accuracy checker |
| test_active | output | 1 | Offline test in progress |
| chan_sel | output | 4 | One-hot channel under offline test |
| seq_done | output | 1 | Offline sequence finished |
| irq | output | 1 | Interrupt request |

## Verification
The assertions assume that `bus_rd` and `bus_wr` are never high together and that every input is stable across the sampling edge. The stimulus therefore drives all inputs on the falling edge and issues one bus operation per strobe. The checker verdict `chk_fail` is assumed to be meaningful at any cycle; the bench holds it through whole offline steps and pulses it during background testing. Offline-bit clears are issued both after the sequence has finished and in the middle of a channel step, which exercises the abort path and the publish path.

// File: rtl/selftest_pkg.sv
package selftest_pkg;

  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_CHAN = 2'd1,
    SEQ_DONE = 2'd2
  } seq_state_e;

  localparam logic [1:0] ADDR_ENABLE = 2'd0;
  localparam logic [1:0] ADDR_VERIFY = 2'd1;
  localparam logic [1:0] ADDR_STATUS = 2'd2;

  localparam int BG_BIT  = 2;
  localparam int OFF_BIT = 3;

  localparam logic [7:0] ALIVE_MARK = 8'h55;
  localparam int unsigned OFFLINE_CAP_SECS = 10;

  // Cycles per channel step: the budget (capped) split evenly over the channels.
  function automatic int unsigned step_len(input int unsigned tps,
                                           input int unsigned secs,
                                           input int unsigned nch);
    int unsigned s;
    int unsigned r;
    s = (secs > OFFLINE_CAP_SECS) ? OFFLINE_CAP_SECS : secs;
    if (s == 0) s = 1;
    r = (tps * s) / nch;
    return (r == 0) ? 1 : r;
  endfunction

  // Counter width able to hold values 0 .. limit-1.
  function automatic int unsigned cnt_width(input int unsigned limit);
    return (limit < 2) ? 1 : $clog2(limit);
  endfunction

endpackage

// File: rtl/st_heartbeat.sv
module st_heartbeat
  import selftest_pkg::*;
#(
  parameter int unsigned TICKS_PER_SEC = 200_000_000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bg_en,
  input  logic       sw_wr,
  input  logic [7:0] sw_data,
  output logic [7:0] verify,
  output logic       hb_fire
);

  localparam int unsigned CW = cnt_width(TICKS_PER_SEC);
  localparam logic [CW-1:0] LAST = CW'(TICKS_PER_SEC - 1);

  logic [CW-1:0] sec_cnt;

  assign hb_fire = bg_en && (sec_cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sec_cnt <= '0;
    end else if (!bg_en || hb_fire) begin
      sec_cnt <= '0;
    end else begin
      sec_cnt <= sec_cnt + CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      verify <= '0;
    end else if (hb_fire) begin
      verify <= ALIVE_MARK;
    end else if (sw_wr) begin
      verify <= sw_data;
    end
  end

  // R2, R3
  hb_mark_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hb_fire |=> (verify == ALIVE_MARK));

endmodule

// File: rtl/st_offline_seq.sv
module st_offline_seq
  import selftest_pkg::*;
#(
  parameter int unsigned NUM_CH     = 4,
  parameter int unsigned STEP_TICKS = 400_000_000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              off_en,
  input  logic [NUM_CH-1:0] chk_fail,
  output logic [NUM_CH-1:0] chan_sel,
  output logic              seq_done,
  output logic              step_end,
  output logic [NUM_CH-1:0] pending
);

  localparam int unsigned CW = cnt_width(STEP_TICKS);
  localparam int unsigned IW = cnt_width(NUM_CH);
  localparam logic [CW-1:0] CNT_LAST = CW'(STEP_TICKS - 1);
  localparam logic [IW-1:0] IDX_LAST = IW'(NUM_CH - 1);

  seq_state_e    state;
  logic [IW-1:0] idx;
  logic [CW-1:0] cnt;

  for (genvar g = 0; g < NUM_CH; g++) begin : g_sel
    assign chan_sel[g] = (state == SEQ_CHAN) && (idx == IW'(g));
  end

  assign seq_done = (state == SEQ_DONE);
  assign step_end = (state == SEQ_CHAN) && off_en && (cnt == CNT_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= SEQ_IDLE;
      idx     <= '0;
      cnt     <= '0;
      pending <= '0;
    end else begin
      unique case (state)
        SEQ_IDLE: if (off_en) begin
          state   <= SEQ_CHAN;
          idx     <= '0;
          cnt     <= '0;
          pending <= '0;
        end
        SEQ_CHAN: begin
          if (!off_en) begin
            state <= SEQ_IDLE;
          end else if (step_end) begin
            pending <= pending | (chan_sel & chk_fail);
            cnt     <= '0;
            if (idx == IDX_LAST) state <= SEQ_DONE;
            else                 idx   <= idx + IW'(1);
          end else begin
            cnt <= cnt + CW'(1);
          end
        end
        SEQ_DONE: if (!off_en) state <= SEQ_IDLE;
        default:  state <= SEQ_IDLE;
      endcase
    end
  end

  // R4
  sel_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(chan_sel) && !(seq_done && (chan_sel != '0)));

  // R5
  abort_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !off_en |=> (chan_sel == '0) && !seq_done);

  // R6
  verdict_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state != SEQ_IDLE) |=> ((pending & $past(pending)) == $past(pending)));

endmodule

// File: rtl/st_status_latch.sv
module st_status_latch #(
  parameter int unsigned NUM_CH = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bg_en,
  input  logic [NUM_CH-1:0] chk_fail,
  input  logic              publish,
  input  logic [NUM_CH-1:0] pending,
  input  logic              rd_hit,
  output logic [NUM_CH-1:0] status
);

  logic [NUM_CH-1:0] set_mask;
  logic [NUM_CH-1:0] clr_mask;

  assign set_mask = (bg_en ? chk_fail : '0) | (publish ? pending : '0);
  assign clr_mask = rd_hit ? status : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) status <= '0;
    else        status <= (status & ~clr_mask) | set_mask;
  end

  // R7
  hold_until_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_hit |=> ((status & $past(status)) == $past(status)));

  // R8
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (set_mask != '0) |=> ((status & $past(set_mask)) == $past(set_mask)));

  // R7
  quiet_no_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!bg_en && !publish) |=> ((status & ~$past(status)) == '0));

endmodule

// File: rtl/selftest_ctrl.sv
module selftest_ctrl
  import selftest_pkg::*;
#(
  parameter int unsigned NUM_CH        = 4,
  parameter int unsigned DATA_W        = 16,
  parameter int unsigned TICKS_PER_SEC = 200_000_000,
  parameter int unsigned OFFLINE_SECS  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [1:0]        bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              irq_en,
  input  logic [NUM_CH-1:0] chk_fail,
  output logic              test_active,
  output logic [NUM_CH-1:0] chan_sel,
  output logic              seq_done,
  output logic              irq
);

  localparam int unsigned STEP_TICKS = step_len(TICKS_PER_SEC, OFFLINE_SECS, NUM_CH);

  logic              bg_en;
  logic              off_en;
  logic              en_wr;
  logic              ver_wr;
  logic              stat_rd;
  logic              publish;
  logic              hb_fire;
  logic              step_end;
  logic [7:0]        verify;
  logic [NUM_CH-1:0] pending;
  logic [NUM_CH-1:0] status;
  logic [DATA_W-1:0] rd_mux;

  assign en_wr   = bus_wr && (bus_addr == ADDR_ENABLE);
  assign ver_wr  = bus_wr && (bus_addr == ADDR_VERIFY);
  assign stat_rd = bus_rd && (bus_addr == ADDR_STATUS);
  assign publish = en_wr && off_en && !bus_wdata[OFF_BIT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bg_en  <= 1'b0;
      off_en <= 1'b0;
    end else if (en_wr) begin
      bg_en  <= bus_wdata[BG_BIT];
      off_en <= bus_wdata[OFF_BIT];
    end
  end

  st_heartbeat #(.TICKS_PER_SEC(TICKS_PER_SEC)) u_hb (
    .clk     (clk),
    .rst_n   (rst_n),
    .bg_en   (bg_en),
    .sw_wr   (ver_wr),
    .sw_data (bus_wdata[7:0]),
    .verify  (verify),
    .hb_fire (hb_fire)
  );

  st_offline_seq #(.NUM_CH(NUM_CH), .STEP_TICKS(STEP_TICKS)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .off_en   (off_en),
    .chk_fail (chk_fail),
    .chan_sel (chan_sel),
    .seq_done (seq_done),
    .step_end (step_end),
    .pending  (pending)
  );

  st_status_latch #(.NUM_CH(NUM_CH)) u_stat (
    .clk      (clk),
    .rst_n    (rst_n),
    .bg_en    (bg_en),
    .chk_fail (chk_fail),
    .publish  (publish),
    .pending  (pending),
    .rd_hit   (stat_rd),
    .status   (status)
  );

  always_comb begin
    rd_mux = '0;
    unique case (bus_addr)
      ADDR_ENABLE: begin
        rd_mux[BG_BIT]  = bg_en;
        rd_mux[OFF_BIT] = off_en;
      end
      ADDR_VERIFY: rd_mux[7:0]        = verify;
      ADDR_STATUS: rd_mux[NUM_CH-1:0] = status;
      default:     rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_mux;
  end

  assign test_active = off_en;
  assign irq         = irq_en && (status != '0);

  // R11
  rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |=> $stable(bus_rdata));

  // R9
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> irq_en);

  // R10
  active_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en_wr && bus_wdata[OFF_BIT]) |=> test_active);

endmodule

// File: tb/selftest_ctrl_tb.sv
module selftest_ctrl_tb;

  localparam int TPS  = 16;
  localparam int SECS = 8;
  localparam int STEP = TPS * SECS / 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [1:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic        irq_en = 1'b0;
  logic [3:0]  chk_fail = '0;
  logic        test_active, seq_done, irq;
  logic [3:0]  chan_sel;

  int checks = 0, fails = 0, cyc = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  selftest_ctrl #(.TICKS_PER_SEC(TPS), .OFFLINE_SECS(SECS)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_en(irq_en), .chk_fail(chk_fail), .test_active(test_active),
    .chan_sel(chan_sel), .seq_done(seq_done), .irq(irq)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  // Behavioural reference model, advanced on every rising edge.
  bit        m_bg, m_off;
  int        m_sec, m_state, m_idx, m_scnt;
  bit [7:0]  m_ver;
  bit [3:0]  m_stat, m_pend;
  bit [15:0] m_rdata;

  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      m_bg = 0; m_off = 0; m_sec = 0; m_state = 0; m_idx = 0; m_scnt = 0;
      m_ver = 0; m_stat = 0; m_pend = 0; m_rdata = 0;
    end else begin
      bit fire, en_w, pub, n_bg, n_off;
      bit [3:0] setm, clrm, n_stat, n_pend;
      bit [7:0] n_ver;
      bit [15:0] n_rd;
      int n_sec, n_state, n_idx, n_scnt;
      fire  = m_bg && (m_sec == TPS - 1);
      n_sec = (!m_bg || fire) ? 0 : m_sec + 1;
      n_ver = fire ? 8'h55 : ((bus_wr && bus_addr == 2'd1) ? bus_wdata[7:0] : m_ver);
      en_w  = bus_wr && bus_addr == 2'd0;
      pub   = en_w && m_off && !bus_wdata[3];
      setm  = (m_bg ? chk_fail : 4'h0) | (pub ? m_pend : 4'h0);
      clrm  = (bus_rd && bus_addr == 2'd2) ? m_stat : 4'h0;
      n_stat = (m_stat & ~clrm) | setm;
      n_rd = m_rdata;
      if (bus_rd) begin
        case (bus_addr)
          2'd0: n_rd = {12'h0, m_off, m_bg, 2'b00};
          2'd1: n_rd = {8'h0, m_ver};
          2'd2: n_rd = {12'h0, m_stat};
          default: n_rd = 16'h0;
        endcase
      end
      n_state = m_state; n_idx = m_idx; n_scnt = m_scnt; n_pend = m_pend;
      if (m_state == 0) begin
        if (m_off) begin n_state = 1; n_idx = 0; n_scnt = 0; n_pend = 0; end
      end else if (m_state == 1) begin
        if (!m_off) n_state = 0;
        else if (m_scnt == STEP - 1) begin
          if (chk_fail[m_idx]) n_pend[m_idx] = 1'b1;
          n_scnt = 0;
          if (m_idx == 3) n_state = 2; else n_idx = m_idx + 1;
        end else n_scnt = m_scnt + 1;
      end else if (!m_off) n_state = 0;
      n_bg  = en_w ? bus_wdata[2] : m_bg;
      n_off = en_w ? bus_wdata[3] : m_off;
      m_bg = n_bg; m_off = n_off; m_sec = n_sec; m_ver = n_ver; m_stat = n_stat;
      m_rdata = n_rd; m_state = n_state; m_idx = n_idx; m_scnt = n_scnt; m_pend = n_pend;
    end
  end

  // Compare against the model on every falling edge.
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      check("R11 rdata", bus_rdata, m_rdata);
      check("R10 test_active", test_active, m_off);
      check("R9 irq", irq, irq_en && (m_stat != 0));
      check("R4 chan_sel", chan_sel, (m_state == 1) ? (4'b1 << m_idx) : 4'b0);
      check("R4 seq_done", seq_done, m_state == 2);
    end
  end

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk); bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] d);
    @(negedge clk); bus_rd = 1; bus_addr = a;
    @(negedge clk); bus_rd = 0; d = bus_rdata;
  endtask

  task automatic finish_run();
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    logic [15:0] d;
    repeat (3) @(negedge clk);
    check("R1 reset rdata", bus_rdata, 16'h0);
    check("R1 reset irq", irq, 1'b0);
    check("R1 reset active", test_active, 1'b0);
    rst_n = 1;
    @(negedge clk);

    // R1: only bits 2 and 3 are kept
    wr(2'd0, 16'hFFF3);
    rd(2'd0, d); check("R1 ignored bits", d, 16'h0000);
    rd(2'd3, d); check("R11 unmapped read", d, 16'h0000);

    // R2: heartbeat after enabling background test
    wr(2'd0, 16'h0004);
    rd(2'd0, d); check("R1 bg bit readback", d, 16'h0004);
    repeat (TPS) @(negedge clk);
    rd(2'd1, d); check("R2 heartbeat mark", d, 16'h0055);
    // R3: software clear then recovery
    wr(2'd1, 16'h0000);
    rd(2'd1, d); check("R3 cleared verify", d, 16'h0000);
    repeat (TPS) @(negedge clk);
    rd(2'd1, d); check("R3 mark restored", d, 16'h0055);

    // R7 / R9: background failure latch and interrupt
    irq_en = 1;
    @(negedge clk); chk_fail = 4'b0010;
    @(negedge clk); chk_fail = 4'b0000;
    check("R9 irq on failure", irq, 1'b1);
    rd(2'd2, d); check("R7 background latch", d, 16'h0002);
    rd(2'd2, d); check("R8 clear on read", d, 16'h0000);
    check("R9 irq cleared", irq, 1'b0);

    // R8: set and read in the same cycle, set wins
    @(negedge clk); bus_rd = 1; bus_addr = 2'd2; chk_fail = 4'b0001;
    @(negedge clk); bus_rd = 0; chk_fail = 4'b0000;
    check("R8 read returns old", bus_rdata, 16'h0000);
    rd(2'd2, d); check("R8 latch wins", d, 16'h0001);
    irq_en = 0;

    // R7: background off, verdicts ignored
    wr(2'd0, 16'h0000);
    @(negedge clk); chk_fail = 4'b1111;
    @(negedge clk); chk_fail = 4'b0000;
    rd(2'd2, d); check("R7 ignored when off", d, 16'h0000);

    // R4 / R6 / R10: full offline sequence
    chk_fail = 4'b0101;
    wr(2'd0, 16'h0008);
    check("R10 active set", test_active, 1'b1);
    @(negedge clk); check("R4 channel 1", chan_sel, 4'b0001);
    repeat (STEP) @(negedge clk); check("R4 channel 2", chan_sel, 4'b0010);
    repeat (3 * STEP) @(negedge clk); check("R4 done", seq_done, 1'b1);
    chk_fail = 4'b0000;
    rd(2'd2, d); check("R6 hidden before clear", d, 16'h0000);
    wr(2'd0, 16'h0000);
    check("R10 active clear", test_active, 1'b0);
    rd(2'd2, d); check("R6 published", d, 16'h0005);
    rd(2'd2, d); check("R8 published cleared", d, 16'h0000);

    // R5: abort in mid step
    wr(2'd0, 16'h0008);
    repeat (10) @(negedge clk);
    wr(2'd0, 16'h0000);
    @(negedge clk); check("R5 abort idle", chan_sel, 4'b0000);
    check("R5 abort not done", seq_done, 1'b0);
    rd(2'd2, d); check("R6 abort no failures", d, 16'h0000);

    repeat (5) @(negedge clk);
    finish_run();
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

endmodule